// File: doc/BRIEF.md
# Register-Mapped GPIO Bank with Per-Pin Function Select

This block serves one bank of up to 32 pads from a simple 32-bit register bus. It has an address, a write strobe, write data and combinational read data. Each pad is governed by three control bits, one bit per pad in each of three registers. The ownership bit decides whether the pad belongs to software as a GPIO or stays with its on-chip hardware function. The direction bit decides whether a GPIO pad drives or listens. The level bit holds the value driven when the pad is an output.

Pad inputs are brought into the clock domain through a synchronizer of at least two flops. Reads of the level register return the driven level for GPIO outputs. For every other pad they return the synchronized pad state. A pad that is not owned by software passes the native function's output-enable and output data straight to the pad, so the hardware function keeps control after reset.

Top module: `gpio_fsel_bank`

## Requirements
- R1: After reset, all three control registers read as 0, so every pad is in native mode and pad_oe/pad_out equal nat_oe/nat_out.
- R2: A write with bus_we high takes effect on the next rising clock edge. Byte offset 0 holds ownership, offset 4 holds direction and offset 8 holds level. A read of the same offset afterwards returns the written value.
- R3: A pad whose ownership bit is 0 drives pad_oe from nat_oe and pad_out from nat_out, whatever its direction and level bits hold.
- R4: A pad with ownership 1 and direction 0 is a GPIO output: pad_oe is 1 and pad_out equals its level bit.
- R5: A pad with ownership 1 and direction 1 is a GPIO input: pad_oe is 0, and pad_out carries its level bit.
- R6: Reading offset 8 returns, for each GPIO output pad, the level bit it drives rather than the pad input.
- R7: Reading offset 8 returns, for GPIO input pads and native pads, the pad input after the synchronizer. A change on pad_in becomes visible after the second rising edge and not after the first.
- R8: Any offset other than 0, 4 or 8, including misaligned ones, reads as 0, and a write there changes no register.
- R9: Read data follows bus_addr combinationally, in the same cycle, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (4) | Byte offset within the bank |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | NUM_PINS (32) | Raw pad input levels |
| pad_oe | output | NUM_PINS (32) | Pad output enables |
| pad_out | output | NUM_PINS (32) | Pad output data |
| nat_oe | input | NUM_PINS (32) | Output enables from the native functions |
| nat_out | input | NUM_PINS (32) | Output data from the native functions |

## Verification
A register write and a pad-input change can land in the same cycle. In that case the level readback must switch its source at the edge the write commits. The bench turns a GPIO input into an output in the very cycle its pad toggles, then reads level right after the edge. It expects the driven level bit and not the synchronized pad. It also turns the pad back into an input while a different pad value is already synchronized, and expects that value at once. Random configurations with random pad and native stimulus are judged against bench functions for pad_oe, pad_out and the readback.

// File: rtl/gpio_fsel_pkg.sv
package gpio_fsel_pkg;

   localparam int DATA_W  = 32;
   localparam int DEC_W   = 16;
   localparam int OFS_OWN = 0;
   localparam int OFS_DIR = 4;
   localparam int OFS_LVL = 8;

   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_OWN  = 2'd1,
      SEL_DIR  = 2'd2,
      SEL_LVL  = 2'd3
   } reg_sel_e;

   function automatic reg_sel_e decode_ofs(input logic [DEC_W-1:0] ofs);
      reg_sel_e sel;
      case (ofs)
         DEC_W'(OFS_OWN): sel = SEL_OWN;
         DEC_W'(OFS_DIR): sel = SEL_DIR;
         DEC_W'(OFS_LVL): sel = SEL_LVL;
         default:         sel = SEL_NONE;
      endcase
      return sel;
   endfunction

endpackage

// File: rtl/gpio_fsel_sync.sv
module gpio_fsel_sync #(
   parameter int WIDTH  = 32,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_fsel_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      end else begin
         stage_q[0] <= async_in;
         for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
   end

   assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_fsel_padmux.sv
module gpio_fsel_padmux #(
   parameter int NUM_PINS = 32
) (
   input  logic [NUM_PINS-1:0] own_q,
   input  logic [NUM_PINS-1:0] dir_q,
   input  logic [NUM_PINS-1:0] lvl_q,
   input  logic [NUM_PINS-1:0] pin_sync,
   input  logic [NUM_PINS-1:0] nat_oe,
   input  logic [NUM_PINS-1:0] nat_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] lvl_view
);

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic sw_drive;
      assign sw_drive    = own_q[p] & ~dir_q[p];
      assign pad_oe[p]   = own_q[p] ? ~dir_q[p] : nat_oe[p];
      assign pad_out[p]  = own_q[p] ? lvl_q[p]  : nat_out[p];
      assign lvl_view[p] = sw_drive ? lvl_q[p]  : pin_sync[p];
   end

endmodule

// File: rtl/gpio_fsel_regs.sv
module gpio_fsel_regs
   import gpio_fsel_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int ADDR_W   = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   addr,
   input  logic                we,
   input  logic [DATA_W-1:0]   wdata,
   input  logic [NUM_PINS-1:0] lvl_view,
   output logic [NUM_PINS-1:0] own_q,
   output logic [NUM_PINS-1:0] dir_q,
   output logic [NUM_PINS-1:0] lvl_q,
   output logic [DATA_W-1:0]   rdata
);

   localparam int PAD_W = DATA_W - NUM_PINS;

   reg_sel_e            sel;
   logic [NUM_PINS-1:0] wbits;
   logic [NUM_PINS-1:0] rbits;

   assign sel   = decode_ofs(DEC_W'(addr));
   assign wbits = wdata[NUM_PINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q <= '0;
         dir_q <= '0;
         lvl_q <= '0;
      end else if (we) begin
         case (sel)
            SEL_OWN: own_q <= wbits;
            SEL_DIR: dir_q <= wbits;
            SEL_LVL: lvl_q <= wbits;
            default: ;
         endcase
      end
   end

   always_comb begin
      case (sel)
         SEL_OWN: rbits = own_q;
         SEL_DIR: rbits = dir_q;
         SEL_LVL: rbits = lvl_view;
         default: rbits = '0;
      endcase
   end

   generate
      if (PAD_W > 0) begin : g_pad
         assign rdata = {{PAD_W{1'b0}}, rbits};
      end else begin : g_full
         assign rdata = rbits;
      end
   endgenerate

endmodule

// File: rtl/gpio_fsel_bank.sv
module gpio_fsel_bank
   import gpio_fsel_pkg::*;
#(
   parameter int NUM_PINS    = 32,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic                bus_we,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic [DATA_W-1:0]   bus_rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out,
   input  logic [NUM_PINS-1:0] nat_oe,
   input  logic [NUM_PINS-1:0] nat_out
);

   generate
      if (NUM_PINS < 1 || NUM_PINS > DATA_W) begin : g_bad_pins
         $error("gpio_fsel_bank: NUM_PINS must be 1..32");
      end
      if (ADDR_W < 4 || ADDR_W > DEC_W) begin : g_bad_addr
         $error("gpio_fsel_bank: ADDR_W must be 4..16");
      end
   endgenerate

   logic [NUM_PINS-1:0] own_q;
   logic [NUM_PINS-1:0] dir_q;
   logic [NUM_PINS-1:0] lvl_q;
   logic [NUM_PINS-1:0] pin_sync;
   logic [NUM_PINS-1:0] lvl_view;

   gpio_fsel_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (pad_in),
      .sync_out (pin_sync)
   );

   gpio_fsel_padmux #(
      .NUM_PINS (NUM_PINS)
   ) u_mux (
      .own_q    (own_q),
      .dir_q    (dir_q),
      .lvl_q    (lvl_q),
      .pin_sync (pin_sync),
      .nat_oe   (nat_oe),
      .nat_out  (nat_out),
      .pad_oe   (pad_oe),
      .pad_out  (pad_out),
      .lvl_view (lvl_view)
   );

   gpio_fsel_regs #(
      .NUM_PINS (NUM_PINS),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (bus_addr),
      .we       (bus_we),
      .wdata    (bus_wdata),
      .lvl_view (lvl_view),
      .own_q    (own_q),
      .dir_q    (dir_q),
      .lvl_q    (lvl_q),
      .rdata    (bus_rdata)
   );

endmodule

// File: rtl/gpio_fsel_chk.sv
module gpio_fsel_chk
   import gpio_fsel_pkg::*;
#(
   parameter int NUM_PINS = 32,
   parameter int ADDR_W   = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                bus_we,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic [DATA_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] nat_oe,
   input logic [NUM_PINS-1:0] nat_out,
   input logic [NUM_PINS-1:0] own_q,
   input logic [NUM_PINS-1:0] dir_q,
   input logic [NUM_PINS-1:0] lvl_q
);

   reg_sel_e sel;
   assign sel = decode_ofs(DEC_W'(bus_addr));

   AST_NATIVE_OE: assert property (@(posedge clk) disable iff (!rst_n)
      ((~own_q & (pad_oe ^ nat_oe)) == '0));                                          // R3
   AST_NATIVE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      ((~own_q & (pad_out ^ nat_out)) == '0));                                        // R3
   AST_GPIO_OUT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      ((own_q & ~dir_q & ~pad_oe) == '0) && ((own_q & (pad_out ^ lvl_q)) == '0));     // R4
   AST_GPIO_IN_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
      ((own_q & dir_q & pad_oe) == '0));                                              // R5
   AST_OWN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_OWN) |=> (own_q == $past(bus_wdata[NUM_PINS-1:0])));      // R2
   AST_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_DIR) |=> (dir_q == $past(bus_wdata[NUM_PINS-1:0])));      // R2
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (bus_rdata == '0));                                       // R8
   AST_UNMAPPED_NOWRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && sel == SEL_NONE) |=> ($stable(own_q) && $stable(dir_q) && $stable(lvl_q))); // R8

endmodule

bind gpio_fsel_bank gpio_fsel_chk #(
   .NUM_PINS (NUM_PINS),
   .ADDR_W   (ADDR_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_oe    (pad_oe),
   .pad_out   (pad_out),
   .nat_oe    (nat_oe),
   .nat_out   (nat_out),
   .own_q     (own_q),
   .dir_q     (dir_q),
   .lvl_q     (lvl_q)
);

// File: tb/test_gpio_fsel_bank.sv
`timescale 1ns/1ps
module test_gpio_fsel_bank;

   localparam int N  = 32;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic          bus_we = 1'b0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [N-1:0]  pad_in = '0;
   logic [N-1:0]  pad_oe;
   logic [N-1:0]  pad_out;
   logic [N-1:0]  nat_oe = '0;
   logic [N-1:0]  nat_out = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [N-1:0] m_own = '0, m_dir = '0, m_lvl = '0;

   always #2.5 clk = ~clk;

   gpio_fsel_bank #(.NUM_PINS(N), .ADDR_W(AW)) i_gpio_fsel_bank (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .nat_oe(nat_oe), .nat_out(nat_out)
   );

   function automatic logic [N-1:0] exp_oe(input logic [N-1:0] o, d, n);
      return (o & ~d) | (~o & n);
   endfunction
   function automatic logic [N-1:0] exp_out(input logic [N-1:0] o, l, n);
      return (o & l) | (~o & n);
   endfunction
   function automatic logic [N-1:0] exp_lvl(input logic [N-1:0] o, d, l, p);
      return ((o & ~d) & l) | (~(o & ~d) & p);
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(posedge clk);
      #1 bus_we = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      bus_addr = a;
      #0.5 d = bus_rdata;
   endtask

   task automatic cfg(input logic [N-1:0] o, d, l);
      wr(4'd0, o); wr(4'd4, d); wr(4'd8, l);
      m_own = o; m_dir = d; m_lvl = l;
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      void'($urandom(32'd2718));
      nat_oe = 32'hA5A5_0F0F; nat_out = 32'h3C3C_F00F;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'd0, r); check("R1 own", r, 0);
      rd(4'd4, r); check("R1 dir", r, 0);
      check("R1 pad_oe", pad_oe, nat_oe);
      check("R1 pad_out", pad_out, nat_out);

      // R9 combinational read, R2 write and readback
      wr(4'd4, 32'h1234_5678); m_dir = 32'h1234_5678;
      rd(4'd4, r); check("R2 dir readback", r, 32'h1234_5678);
      rd(4'd0, r); check("R9 same-cycle addr switch", r, 0);
      wr(4'd0, 32'hFFFF_0000); m_own = 32'hFFFF_0000;
      rd(4'd0, r); check("R2 own readback", r, 32'hFFFF_0000);

      // R8 unmapped and misaligned offsets
      wr(4'd12, 32'hFFFF_FFFF);
      wr(4'd5,  32'hFFFF_FFFF);
      wr(4'd1,  32'hFFFF_FFFF);
      rd(4'd12, r); check("R8 read 12", r, 0);
      rd(4'd9,  r); check("R8 read 9", r, 0);
      rd(4'd0, r); check("R8 own kept", r, m_own);
      rd(4'd4, r); check("R8 dir kept", r, m_dir);

      // R7 two-stage latency on a native pad
      cfg(32'h0, 32'h0, 32'h0);
      @(negedge clk); pad_in = 32'h0000_0001;
      @(posedge clk); #1;
      rd(4'd8, r); check("R7 not after first edge", r, 0);
      @(posedge clk); #1;
      rd(4'd8, r); check("R7 visible after second edge", r, 32'h1);

      // R6/R7 same-cycle: write dir to output while pad toggles
      cfg(32'h1, 32'h1, 32'h0);
      @(negedge clk); pad_in = 32'h1;
      repeat (3) @(posedge clk); #1;
      rd(4'd8, r); check("R7 input pad read", r, 32'h1);
      @(negedge clk);
      bus_addr = 4'd4; bus_wdata = 32'h0; bus_we = 1'b1; pad_in = 32'h0;
      @(posedge clk); #1 bus_we = 1'b0; m_dir = 32'h0;
      rd(4'd8, r); check("R6 output reads level not pad", r, 32'h0);
      check("R4 oe after switch", pad_oe[0], 1'b1);
      wr(4'd8, 32'h1); m_lvl = 32'h1;
      rd(4'd8, r); check("R6 level 1 with pad 0", r, 32'h1);
      check("R4 pad_out", pad_out[0], 1'b1);
      @(negedge clk); pad_in = 32'h0;
      repeat (3) @(posedge clk); #1;
      wr(4'd4, 32'h1); m_dir = 32'h1;
      rd(4'd8, r); check("R7 back to input reads synced pad", r, 32'h0);
      check("R5 oe low", pad_oe[0], 1'b0);

      // random configurations
      for (int i = 0; i < 40; i++) begin
         logic [N-1:0] o, d, l;
         o = $urandom; d = $urandom; l = $urandom;
         if (i % 8 == 0) o = '0;
         if (i % 8 == 1) o = '1;
         cfg(o, d, l);
         @(negedge clk);
         pad_in = $urandom; nat_oe = $urandom; nat_out = $urandom;
         repeat (3) @(posedge clk); #1;
         check("R3/R4/R5 pad_oe", pad_oe, exp_oe(m_own, m_dir, nat_oe));
         check("R3/R4/R5 pad_out", pad_out, exp_out(m_own, m_lvl, nat_out));
         rd(4'd8, r); check("R6/R7 level read", r, exp_lvl(m_own, m_dir, m_lvl, pad_in));
         rd(4'd0, r); check("R2 own", r, m_own);
         rd(4'd4, r); check("R2 dir", r, m_dir);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule